// File: doc/BRIEF.md
# Macro Sequencer Execute Unit (Arithmetic and Bitfield)

This block is the execute stage of a small macro sequencer. It decodes one 32-bit instruction word. From that word and two source register values it produces a 32-bit result. It covers five operation classes: a register-register ALU, add of a signed immediate, extract-and-insert of a bit field, and two extract-then-shift-left forms. In each shift-left form, one shift distance comes from a register. The datapath from the inputs to the result is purely combinational. The result and the illegal-operation flag therefore follow the inputs in the same cycle.

The only state in the block is a one-bit carry flag. The arithmetic ALU codes write it when the instruction is issued. The carry-consuming codes read it. Register writeback, branching, parameter fetch and memory reads are handled by the surrounding sequencer and are not part of this block.

Top module: `mbx_exec_unit`

## Requirements
- R1: The operation class is `insn[2:0]`: 0 ALU, 1 add-immediate, 2 extract-insert, 3 extract-shift-left by immediate, 4 extract-shift-left by register. Classes 5, 6 and 7 give a zero result with the illegal flag low, and they leave the carry flag unchanged.
- R2: The ALU sub-code is `insn[21:17]`. The codes are 0 A+B, 2 A-B, 8 A^B, 9 A|B, 10 A&B, 11 A&~B and 12 ~(A&B), all modulo 2^32.
- R3: ALU code 1 returns A+B+C, and ALU code 3 returns A+~B+C, where C is the stored carry flag.
- R4: The carry flag is 0 after reset. When `issue` is high with an ALU instruction of code 0 to 3, the flag takes the carry out of bit 31 of that code's 33-bit sum at the clock edge. For subtraction this carry out is 1 when no borrow occurs. In all other cycles the flag holds its value.
- R5: ALU codes 4 to 7 and 13 to 31 give a zero result with the illegal flag high, and they never change the carry flag.
- R6: Add-immediate returns A plus the sign-extended 18-bit value in `insn[31:14]`.
- R7: The bitfield operations read a source position from `insn[21:17]`, a size from `insn[26:22]` and a destination position from `insn[31:27]`. The field mask is (1 << size) - 1, so a size of 0 selects an empty field.
- R8: Extract-insert takes the field of B that starts at the source position and writes it into A at the destination position. All other bits of A pass through unchanged, and field bits that land above bit 31 are dropped.
- R9: Extract-shift-left by immediate shifts B right by the value of A, masks the result, and then shifts it left by the destination position. A value of 32 or more in A gives zero.
- R10: Extract-shift-left by register shifts B right by the source position, masks the result, and then shifts it left by the value of A. A value of 32 or more in A gives zero.
- R11: The result and the illegal flag depend combinationally on `insn`, `src_a`, `src_b` and the stored carry, with no clock edge between an input change and the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the carry flag |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | The current instruction is committed, so the carry flag may update |
| insn | input | 32 | Instruction word |
| src_a | input | 32 | Source A register value |
| src_b | input | 32 | Source B register value |
| result | output | 32 | Operation result |
| illegal | output | 1 | The ALU sub-code is not a valid encoding |

## Verification
The carry flag is the only hidden state, so a wrong flag can only be seen through the carry-consuming codes 1 and 3. On the first such instruction after the fault, the result is off by exactly one, and this appears in the same cycle the instruction is presented. The bench therefore reads the flag back with a carry-consuming code after each carry-writing, illegal or non-issued instruction. A fault in the decode of a packed field shows up at once as a wrong result for the operation class concerned. Random operands and random field values make such faults visible within a few instructions.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int DW    = 32;   // datapath width
    localparam int FW    = 5;    // packed position/size field width
    localparam int IMM_W = 18;   // signed immediate width

    typedef enum logic [2:0] {
        OP_ALU     = 3'd0,
        OP_ADDI    = 3'd1,
        OP_INSERT  = 3'd2,
        OP_XSL_IMM = 3'd3,
        OP_XSL_REG = 3'd4,
        OP_LOAD    = 3'd5,
        OP_RSVD    = 3'd6,
        OP_JUMP    = 3'd7
    } op_e;

    localparam logic [4:0] ALU_ADD  = 5'd0;
    localparam logic [4:0] ALU_ADDC = 5'd1;
    localparam logic [4:0] ALU_SUB  = 5'd2;
    localparam logic [4:0] ALU_SUBB = 5'd3;
    localparam logic [4:0] ALU_XOR  = 5'd8;
    localparam logic [4:0] ALU_OR   = 5'd9;
    localparam logic [4:0] ALU_AND  = 5'd10;
    localparam logic [4:0] ALU_ANDN = 5'd11;
    localparam logic [4:0] ALU_NAND = 5'd12;

    typedef struct packed {
        op_e               op;
        logic [4:0]        alu_code;
        logic [FW-1:0]     src_pos;
        logic [FW-1:0]     fld_size;
        logic [FW-1:0]     dst_pos;
        logic [IMM_W-1:0]  imm;
    } dec_t;

    function automatic dec_t decode(input logic [DW-1:0] w);
        dec_t d;
        d.op       = op_e'(w[2:0]);
        d.alu_code = w[21:17];
        d.src_pos  = w[21:17];
        d.fld_size = w[26:22];
        d.dst_pos  = w[31:27];
        d.imm      = w[31:14];
        return d;
    endfunction

    function automatic logic [DW-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(DW-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [DW-1:0] field_mask(input logic [FW-1:0] sz);
        return (DW'(1) << sz) - DW'(1);
    endfunction

endpackage

// File: rtl/mbx_alu_core.sv
module mbx_alu_core
    import mbx_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [4:0]   code,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         arith,
    output logic         bad
);
    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   sum;

    // code[1] selects subtraction, code[0] selects the stored carry
    always_comb begin
        b_eff = code[1] ? ~b : b;
        c_eff = code[0] ? cin : code[1];
        sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    end

    assign cout = sum[W];

    always_comb begin
        res   = '0;
        bad   = 1'b0;
        arith = 1'b0;
        case (code)
            ALU_ADD, ALU_ADDC, ALU_SUB, ALU_SUBB: begin
                res   = sum[W-1:0];
                arith = 1'b1;
            end
            ALU_XOR:  res = a ^ b;
            ALU_OR:   res = a | b;
            ALU_AND:  res = a & b;
            ALU_ANDN: res = a & ~b;
            ALU_NAND: res = ~(a & b);
            default:  bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/mbx_bitfield_core.sv
module mbx_bitfield_core
    import mbx_pkg::*;
#(
    parameter int W = DW,
    parameter int F = FW
) (
    input  op_e          sel,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [F-1:0] src_pos,
    input  logic [F-1:0] fld_size,
    input  logic [F-1:0] dst_pos,
    output logic [W-1:0] res
);
    logic [W-1:0] mask;
    logic [W-1:0] fld_fixed;
    logic [W-1:0] fld_var;
    logic [W-1:0] r_insert;
    logic [W-1:0] r_xsl_imm;
    logic [W-1:0] r_xsl_reg;

    always_comb begin
        mask      = (W'(1) << fld_size) - W'(1);
        fld_fixed = (b >> src_pos) & mask;
        fld_var   = (b >> a) & mask;
        r_insert  = (a & ~(mask << dst_pos)) | (fld_fixed << dst_pos);
        r_xsl_imm = fld_var << dst_pos;
        r_xsl_reg = fld_fixed << a;
    end

    always_comb begin
        case (sel)
            OP_INSERT:  res = r_insert;
            OP_XSL_IMM: res = r_xsl_imm;
            OP_XSL_REG: res = r_xsl_reg;
            default:    res = '0;
        endcase
    end
endmodule

// File: rtl/mbx_flag_reg.sv
module mbx_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= 1'b0;
        else if (en) q <= d;
    end
endmodule

// File: rtl/mbx_exec_unit.sv
module mbx_exec_unit
    import mbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  logic [DW-1:0] insn,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    output logic [DW-1:0] result,
    output logic          illegal
);
    dec_t          dec;
    logic [DW-1:0] alu_res;
    logic [DW-1:0] bf_res;
    logic          alu_cout;
    logic          alu_arith;
    logic          alu_bad;
    logic          carry_q;
    logic          carry_we;
    logic          unused_bits;

    assign dec         = decode(insn);
    assign unused_bits = ^insn[13:3];

    mbx_alu_core #(.W(DW)) alu_i (
        .code  (dec.alu_code),
        .a     (src_a),
        .b     (src_b),
        .cin   (carry_q),
        .res   (alu_res),
        .cout  (alu_cout),
        .arith (alu_arith),
        .bad   (alu_bad)
    );

    mbx_bitfield_core #(.W(DW), .F(FW)) bf_i (
        .sel      (dec.op),
        .a        (src_a),
        .b        (src_b),
        .src_pos  (dec.src_pos),
        .fld_size (dec.fld_size),
        .dst_pos  (dec.dst_pos),
        .res      (bf_res)
    );

    assign carry_we = issue && (dec.op == OP_ALU) && alu_arith;

    mbx_flag_reg carry_i (
        .clk (clk),
        .rst (rst),
        .en  (carry_we),
        .d   (alu_cout),
        .q   (carry_q)
    );

    always_comb begin
        illegal = 1'b0;
        case (dec.op)
            OP_ALU: begin
                result  = alu_res;
                illegal = alu_bad;
            end
            OP_ADDI:                         result = src_a + sext_imm(dec.imm);
            OP_INSERT, OP_XSL_IMM, OP_XSL_REG: result = bf_res;
            default:                         result = '0;
        endcase
    end
endmodule

// File: rtl/mbx_exec_unit_chk.sv
module mbx_exec_unit_chk
    import mbx_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          issue,
    input logic [DW-1:0] insn,
    input logic [DW-1:0] src_a,
    input logic [DW-1:0] src_b,
    input logic [DW-1:0] result,
    input logic          illegal,
    input logic          carry_q
);
    logic          unused_chk;
    logic          carry_write;
    logic [DW-1:0] keep_mask;

    assign unused_chk  = ^{insn[13:3], src_b};
    assign carry_write = issue && (insn[2:0] == 3'd0) && (insn[21:19] == 3'd0);
    assign keep_mask   = ~(field_mask(insn[26:22]) << insn[31:27]);

    assert_illegal_zero_R5: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (result == '0));

    assert_illegal_alu_only_R5: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (insn[2:0] == 3'd0));

    assert_other_ops_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (insn[2:0] >= 3'd5) |-> (result == '0 && !illegal));

    assert_carry_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !carry_write |=> $stable(carry_q));

    assert_reset_clears_R4: assert property (@(posedge clk)
        rst |=> !carry_q);

    assert_insert_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (insn[2:0] == 3'd2) |-> (((result ^ src_a) & keep_mask) == '0));

    assert_addi_sum_R6: assert property (@(posedge clk) disable iff (rst)
        (insn[2:0] == 3'd1) |-> (result - src_a == sext_imm(insn[31:14])));
endmodule

bind mbx_exec_unit mbx_exec_unit_chk chk_i (.*);

// File: tb/mbx_exec_unit_tb.sv
`timescale 1ns/1ps
module mbx_exec_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] result;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit mcarry = 0;

    always #2.5 clk = ~clk;

    mbx_exec_unit dut_i (
        .clk(clk), .rst(rst), .issue(issue), .insn(insn),
        .src_a(src_a), .src_b(src_b), .result(result), .illegal(illegal)
    );

    function automatic logic [31:0] mk_alu(input logic [4:0] code);
        return {10'd0, code, 17'd0};
    endfunction

    function automatic logic [31:0] mk_addi(input logic [17:0] imm);
        return {imm, 14'd0} | 32'd1;
    endfunction

    function automatic logic [31:0] mk_bf(input logic [2:0] op, input logic [4:0] sp,
                                          input logic [4:0] sz, input logic [4:0] dp);
        return {dp, sz, sp, 14'd0, op};
    endfunction

    // Reference model built from the requirements, bit by bit
    function automatic void model(input logic [31:0] w, input logic [31:0] a,
                                  input logic [31:0] b, input bit c,
                                  output logic [31:0] r, output bit ill,
                                  output bit cout, output bit upd);
        int sp, sz, dp;
        logic [32:0] s;
        sp = int'(w[21:17]); sz = int'(w[26:22]); dp = int'(w[31:27]);
        r = '0; ill = 0; cout = c; upd = 0;
        case (w[2:0])
            3'd0: case (w[21:17])
                5'd0:  begin s = {1'b0, a} + {1'b0, b};                   upd = 1; end
                5'd1:  begin s = {1'b0, a} + {1'b0, b} + 33'(c);          upd = 1; end
                5'd2:  begin s = {1'b0, a} + {1'b0, ~b} + 33'd1;          upd = 1; end
                5'd3:  begin s = {1'b0, a} + {1'b0, ~b} + 33'(c);         upd = 1; end
                5'd8:  r = a ^ b;
                5'd9:  r = a | b;
                5'd10: r = a & b;
                5'd11: r = a & ~b;
                5'd12: r = ~(a & b);
                default: ill = 1;
            endcase
            3'd1: r = a + {{14{w[31]}}, w[31:14]};
            3'd2: begin
                r = a;
                for (int k = 0; k < sz; k++)
                    if (k + dp < 32) r[k + dp] = (k + sp < 32) ? b[k + sp] : 1'b0;
            end
            3'd3: begin
                for (int k = 0; k < sz; k++)
                    if (k + dp < 32 && a < 32 && int'(a) + k < 32) r[k + dp] = b[int'(a) + k];
            end
            3'd4: begin
                for (int k = 0; k < sz; k++)
                    if (a < 32 && int'(a) + k < 32 && k + sp < 32) r[int'(a) + k] = b[k + sp];
            end
            default: r = '0;
        endcase
        if (upd) begin
            r = s[31:0];
            cout = s[32];
        end
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                       input bit iss, input string tag);
        logic [31:0] er;
        bit eill, ecout, eupd;
        @(negedge clk);
        insn = w; src_a = a; src_b = b; issue = iss;
        #1;
        model(w, a, b, mcarry, er, eill, ecout, eupd);
        check(tag, result, er);
        check({tag, " flag"}, {31'd0, illegal}, {31'd0, eill});
        if (iss && eupd) mcarry = ecout;
    endtask

    // read back the carry flag with A+B+C on zeros, not issued
    task automatic peek_carry(input bit exp, input string tag);
        run(mk_alu(5'd1), 32'd0, 32'd0, 1'b0, tag);
        check({tag, " carry"}, {31'd0, mcarry}, {31'd0, exp});
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R4 reset state
        peek_carry(1'b0, "R4 reset carry");

        // R2 plain ALU codes
        run(mk_alu(5'd0),  32'd5, 32'd7, 1'b0, "R2 add");
        run(mk_alu(5'd2),  32'd3, 32'd5, 1'b0, "R2 sub");
        run(mk_alu(5'd8),  32'hF0F0_1234, 32'h0FF0_4321, 1'b0, "R2 xor");
        run(mk_alu(5'd9),  32'hF0F0_1234, 32'h0FF0_4321, 1'b0, "R2 or");
        run(mk_alu(5'd10), 32'hF0F0_1234, 32'h0FF0_4321, 1'b0, "R2 and");
        run(mk_alu(5'd11), 32'hF0F0_1234, 32'h0FF0_4321, 1'b0, "R2 andn");
        run(mk_alu(5'd12), 32'hF0F0_1234, 32'h0FF0_4321, 1'b0, "R2 nand");

        // R4/R3 carry chain
        run(mk_alu(5'd0), 32'hFFFF_FFFF, 32'd1, 1'b1, "R4 add carry out");
        peek_carry(1'b1, "R4 carry set");
        run(mk_alu(5'd1), 32'd1, 32'd1, 1'b0, "R3 addc with carry");
        run(mk_alu(5'd1), 32'd1, 32'd1, 1'b1, "R3 addc issued");
        peek_carry(1'b0, "R4 carry cleared");
        run(mk_alu(5'd2), 32'd5, 32'd3, 1'b1, "R4 sub no borrow");
        run(mk_alu(5'd3), 32'd10, 32'd4, 1'b0, "R3 subb carry1");
        run(mk_alu(5'd2), 32'd3, 32'd5, 1'b1, "R4 sub borrow");
        run(mk_alu(5'd3), 32'd10, 32'd4, 1'b0, "R3 subb carry0");
        run(mk_alu(5'd0), 32'hFFFF_FFFF, 32'd1, 1'b0, "R4 add not issued");
        peek_carry(1'b0, "R4 hold when not issued");

        // R5 illegal codes leave carry alone
        run(mk_alu(5'd0), 32'h8000_0000, 32'h8000_0000, 1'b1, "R4 set again");
        run(mk_alu(5'd5),  32'd9, 32'd9, 1'b1, "R5 code 5");
        run(mk_alu(5'd13), 32'd9, 32'd9, 1'b1, "R5 code 13");
        run(mk_alu(5'd31), 32'd9, 32'd9, 1'b1, "R5 code 31");
        peek_carry(1'b1, "R5 carry unchanged");

        // R1 out-of-scope classes
        run(32'hFFFF_FFFD, 32'd1, 32'd2, 1'b1, "R1 class 5");
        run(32'h1234_5677, 32'd1, 32'd2, 1'b1, "R1 class 7");
        peek_carry(1'b1, "R1 carry unchanged");

        // R6 add immediate
        run(mk_addi(18'h3FFFF), 32'd10, 32'd0, 1'b0, "R6 addi minus one");
        run(mk_addi(18'h1FFFF), 32'd1,  32'd0, 1'b0, "R6 addi max");
        run(mk_addi(18'h20000), 32'd0,  32'd0, 1'b0, "R6 addi min");

        // R7/R8 extract-insert
        run(mk_bf(3'd2, 5'd0, 5'd8, 5'd4), 32'hFFFF_FFFF, 32'd0, 1'b0, "R8 insert");
        run(mk_bf(3'd2, 5'd3, 5'd0, 5'd4), 32'hCAFE_BABE, 32'hFFFF_FFFF, 1'b0, "R7 size zero");
        run(mk_bf(3'd2, 5'd28, 5'd31, 5'd30), 32'h1234_5678, 32'hF000_0000, 1'b0, "R8 overflow drop");

        // R9 extract-shift-left immediate
        run(mk_bf(3'd3, 5'd0, 5'd4, 5'd8), 32'd4,  32'h0000_00F0, 1'b0, "R9 shift");
        run(mk_bf(3'd3, 5'd0, 5'd4, 5'd8), 32'd40, 32'hFFFF_FFFF, 1'b0, "R9 large A");

        // R10 extract-shift-left register
        run(mk_bf(3'd4, 5'd4, 5'd4, 5'd0), 32'd16, 32'h0000_00AB, 1'b0, "R10 shift");
        run(mk_bf(3'd4, 5'd4, 5'd4, 5'd0), 32'd33, 32'hFFFF_FFFF, 1'b0, "R10 large A");

        // R11 combinational response without a clock edge
        @(negedge clk);
        insn = mk_alu(5'd0); src_a = 32'd100; src_b = 32'd1; issue = 1'b0;
        #0.5 check("R11 first", result, 32'd101);
        src_a = 32'd200;
        #0.5 check("R11 same cycle", result, 32'd201);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] w, a, b;
            w = $urandom;
            a = $urandom;
            b = $urandom;
            if (($urandom % 3) == 0) a = $urandom % 40;
            if (($urandom % 2) == 0) w[2:0] = 3'($urandom % 5);
            if (($urandom % 3) == 0 && w[2:0] == 3'd0) w[21:17] = 5'($urandom % 4);
            run(w, a, b, 1'($urandom), "R1-mix random");
        end
        peek_carry(mcarry, "R4 final carry");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule